// File: doc/BRIEF.md
# Switch Partition Reset Sequencer

This controller runs the hot-reset sequence for one partition of a multi-port packet switch. Four reset sources feed it. Two are level signals from the upstream port: a received training set that requests hot reset, and the upstream data link going down. Two are single-cycle software write pulses: a partition-state reset request and a secondary-bus-reset request. A control bit can mask the link-down source. When a reset is launched, the sequencer issues one cycle of per-port commands to the downstream ports and pulses a strobe that clears the non-sticky registers. It then holds the partition logic in reset for as long as the level source that caused it stays asserted, and finally gives a one-cycle release so the ports can start link training.

Each downstream port gets a command that depends on its link state. A port whose link is up is told to send hot-reset training sets. A port whose link is disabled is told to move to Detect. A port in neither state gets no command. A secondary-bus reset only tells the ports with links up to send hot reset. It does not reset the partition logic or the registers, and it does not retrain the upstream port.

Top module: `part_rst_seq`

## Requirements
- R1: A hot reset launches when, at a rising clock edge, `us_hotrst_rx` is high, or `us_dl_down` is high, or `sw_part_rst_wr` pulses. In the cycle after that edge, `part_logic_rst` and `nonsticky_clr` are both high.
- R2: While `ctl_no_ld_rst` is 1, `us_dl_down` alone launches no reset. All outputs stay low.
- R3: `ctl_no_ld_rst` has no effect on `us_hotrst_rx`. A received hot-reset training set still launches a hot reset.
- R4: In the launch cycle, `dsp_send_hot[i]` is 1 for every port i with `dsp_link_up[i]`=1 and `dsp_link_dis[i]`=0. In every other cycle it is 0.
- R5: In a hot-reset launch cycle, `dsp_go_detect[i]` is 1 for every port with `dsp_link_dis[i]`=1, and that port's `dsp_send_hot[i]` is 0. A port that is neither up nor disabled receives no command.
- R6: `nonsticky_clr` is high for exactly one cycle, the launch cycle of a hot reset, and never for a secondary-bus reset.
- R7: `part_logic_rst` stays high after the launch cycle for every cycle in which `us_hotrst_rx`, or an unmasked `us_dl_down`, was still high at the preceding edge. A reset launched by a software pulse holds for one cycle after launch.
- R8: After the hold ends, `train_release` is high for exactly one cycle with `part_logic_rst` low. The block then returns to idle with all outputs low.
- R9: A `sw_sbr_wr` pulse launches a secondary-bus reset. Its launch cycle drives `dsp_send_hot` for ports whose link is up, and leaves `dsp_go_detect`, `part_logic_rst` and `nonsticky_clr` low. If a hot-reset source is present at the same edge, the hot reset wins.
- R10: A software pulse that arrives while a sequence is running is remembered. A pending request, or a level source present during the release cycle, launches the next sequence directly from release, without passing through idle.
- R11: After reset (`rst_n` low at a clock edge), every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_hotrst_rx | input | 1 | Upstream port is receiving hot-reset training sets (level) |
| us_dl_down | input | 1 | Upstream data link is down (level) |
| ctl_no_ld_rst | input | 1 | 1 = link-down does not cause a hot reset |
| sw_part_rst_wr | input | 1 | Single-cycle software request for a partition hot reset |
| sw_sbr_wr | input | 1 | Single-cycle software request for a secondary-bus reset |
| dsp_link_up | input | NUM_DSP | Per downstream port: link is up |
| dsp_link_dis | input | NUM_DSP | Per downstream port: link is in the Disabled state |
| dsp_send_hot | output | NUM_DSP | Per port: send training sets with the hot-reset bit set |
| dsp_go_detect | output | NUM_DSP | Per port: move link training to Detect |
| part_logic_rst | output | 1 | Partition logic held in reset |
| nonsticky_clr | output | 1 | One-cycle strobe that returns non-sticky registers to their initial values |
| train_release | output | 1 | One-cycle release so the ports can start link training |

## Verification
The assertions rely on a few properties of the inputs. Every input is synchronous to `clk`. The two software inputs are single-cycle pulses. The link-state vectors are stable during the launch cycle, which is the cycle in which they are decoded. The stimulus drives every input on the falling edge and returns each software request to zero one cycle after raising it. Link vectors are applied together with the trigger and held until the launch cycle has been sampled. Vectors with both up and disabled set for a port are avoided except where the disabled-wins rule is itself being checked.

// File: rtl/prs_pkg.sv
// Package: shared types for the partition reset sequencer.
// Assumes: nothing; holds only type definitions.
package prs_pkg;

    // Sequencer phases: idle, one launch cycle, hold, one release cycle.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PROP = 2'd1,
        ST_HOLD = 2'd2,
        ST_REL  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/prs_trig_merge.sv
// Module: prs_trig_merge
// Merges the reset sources into a hot-reset trigger, a secondary-bus trigger
// and a hold condition. Applies the link-down mask and latches the software
// write pulses until the sequencer consumes them.
// Assumes: all inputs are synchronous to clk; software inputs are one-cycle pulses.
module prs_trig_merge (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_rx,
    input  logic dl_down,
    input  logic mask_dl,
    input  logic sw_hot_wr,
    input  logic sw_sbr_wr,
    input  logic consume,
    output logic hot_trig,
    output logic sbr_trig,
    output logic hot_hold
);

    logic hot_pend_q;
    logic sbr_pend_q;

    // Level sources that keep a hot reset held; link-down only when unmasked.
    always_comb begin
        hot_hold = hot_rx | (dl_down & ~mask_dl);
    end

    // Triggers combine the live pulses with the remembered requests.
    always_comb begin
        hot_trig = hot_hold | sw_hot_wr | hot_pend_q;
        sbr_trig = sw_sbr_wr | sbr_pend_q;
    end

    // Remember software pulses until a launch consumes them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hot_pend_q <= 1'b0;
            sbr_pend_q <= 1'b0;
        end else if (consume) begin
            hot_pend_q <= 1'b0;
            sbr_pend_q <= 1'b0;
        end else begin
            hot_pend_q <= hot_pend_q | sw_hot_wr;
            sbr_pend_q <= sbr_pend_q | sw_sbr_wr;
        end
    end

    // R10: a remembered request is only dropped by a launch
    a_r10_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_pend_q && !consume) |=> hot_pend_q);

endmodule

// File: rtl/prs_seq_fsm.sv
// Module: prs_seq_fsm
// Four-phase sequencer: IDLE -> PROP (one cycle) -> HOLD -> REL (one cycle).
// Records whether the running sequence is a hot reset or a secondary-bus reset.
// Assumes: triggers come from prs_trig_merge in the same cycle.
module prs_seq_fsm
    import prs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hot_trig,
    input  logic       sbr_trig,
    input  logic       hot_hold,
    output logic       launch,
    output logic       cmd_en,
    output logic       kind_hot,
    output logic       part_rst,
    output logic       nsr_clr,
    output logic       rel
);

    seq_state_e st_q, st_d;
    logic       kind_q, kind_d;
    logic       can_launch;

    // Next-state logic; a hot trigger wins over a secondary-bus trigger.
    always_comb begin
        st_d       = st_q;
        kind_d     = kind_q;
        launch     = 1'b0;
        can_launch = (st_q == ST_IDLE) || (st_q == ST_REL);
        case (st_q)
            ST_PROP: st_d = ST_HOLD;
            ST_HOLD: st_d = (kind_q && hot_hold) ? ST_HOLD : ST_REL;
            default: st_d = ST_IDLE;
        endcase
        if (can_launch && (hot_trig || sbr_trig)) begin
            st_d   = ST_PROP;
            kind_d = hot_trig;
            launch = 1'b1;
        end
    end

    // State and kind registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            kind_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            kind_q <= kind_d;
        end
    end

    // Output decode from the registered phase.
    always_comb begin
        cmd_en   = (st_q == ST_PROP);
        kind_hot = kind_q;
        part_rst = kind_q && ((st_q == ST_PROP) || (st_q == ST_HOLD));
        nsr_clr  = kind_q && (st_q == ST_PROP);
        rel      = (st_q == ST_REL);
    end

    // R6: the non-sticky strobe never lasts two cycles
    a_r6_nsr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        nsr_clr |=> !nsr_clr);

    // R7: hold persists while a level source is present
    a_r7_hold_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && kind_q && hot_hold) |=> (st_q == ST_HOLD));

    // R8: release is a single cycle
    a_r8_release_single: assert property (@(posedge clk) disable iff (!rst_n)
        rel |=> !rel);

endmodule

// File: rtl/prs_port_cmd.sv
// Module: prs_port_cmd
// Per-port command decode during the launch cycle. Up links send hot reset.
// Disabled links go to Detect, but only for a hot reset; disabled wins over up.
// Assumes: link state is stable during the launch cycle.
module prs_port_cmd #(
    parameter int NUM_DSP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_en,
    input  logic               kind_hot,
    input  logic [NUM_DSP-1:0] link_up,
    input  logic [NUM_DSP-1:0] link_dis,
    output logic [NUM_DSP-1:0] send_hot,
    output logic [NUM_DSP-1:0] go_detect
);

    for (genvar p = 0; p < NUM_DSP; p++) begin : g_port
        // Decode one port's command from its link state.
        always_comb begin
            send_hot[p]  = cmd_en && link_up[p] && !link_dis[p];
            go_detect[p] = cmd_en && kind_hot && link_dis[p];
        end

        // R5: a port never gets both commands
        a_r5_cmd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            !(send_hot[p] && go_detect[p]));
    end

endmodule

// File: rtl/part_rst_seq.sv
// Module: part_rst_seq (top)
// Partition hot-reset sequencer: merges the reset sources, steps the
// launch/hold/release phases and drives the per-port commands.
// Assumes: inputs are synchronous to clk; software inputs are one-cycle pulses.
module part_rst_seq #(
    parameter int NUM_DSP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               us_hotrst_rx,
    input  logic               us_dl_down,
    input  logic               ctl_no_ld_rst,
    input  logic               sw_part_rst_wr,
    input  logic               sw_sbr_wr,
    input  logic [NUM_DSP-1:0] dsp_link_up,
    input  logic [NUM_DSP-1:0] dsp_link_dis,
    output logic [NUM_DSP-1:0] dsp_send_hot,
    output logic [NUM_DSP-1:0] dsp_go_detect,
    output logic               part_logic_rst,
    output logic               nonsticky_clr,
    output logic               train_release
);

    logic hot_trig, sbr_trig, hot_hold;
    logic launch, cmd_en, kind_hot;

    prs_trig_merge u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .hot_rx    (us_hotrst_rx),
        .dl_down   (us_dl_down),
        .mask_dl   (ctl_no_ld_rst),
        .sw_hot_wr (sw_part_rst_wr),
        .sw_sbr_wr (sw_sbr_wr),
        .consume   (launch),
        .hot_trig  (hot_trig),
        .sbr_trig  (sbr_trig),
        .hot_hold  (hot_hold)
    );

    prs_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hot_trig (hot_trig),
        .sbr_trig (sbr_trig),
        .hot_hold (hot_hold),
        .launch   (launch),
        .cmd_en   (cmd_en),
        .kind_hot (kind_hot),
        .part_rst (part_logic_rst),
        .nsr_clr  (nonsticky_clr),
        .rel      (train_release)
    );

    prs_port_cmd #(.NUM_DSP(NUM_DSP)) u_ports (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_en    (cmd_en),
        .kind_hot  (kind_hot),
        .link_up   (dsp_link_up),
        .link_dis  (dsp_link_dis),
        .send_hot  (dsp_send_hot),
        .go_detect (dsp_go_detect)
    );

    // R1/R2: a partition reset only starts after a hot trigger was seen
    a_r2_rise_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(part_logic_rst) |-> $past(hot_trig));

    // R9: Detect commands only come with a partition (hot) reset
    a_r9_detect_only_hot: assert property (@(posedge clk) disable iff (!rst_n)
        (|dsp_go_detect) |-> part_logic_rst);

    // R6: the register clear strobe only comes inside a partition reset
    a_r6_clear_inside_reset: assert property (@(posedge clk) disable iff (!rst_n)
        nonsticky_clr |-> part_logic_rst);

    // R8: release never overlaps the partition reset
    a_r8_release_not_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        train_release |-> !part_logic_rst);

endmodule

// File: tb/part_rst_seq_bench.sv
`timescale 1ns/1ps
module part_rst_seq_bench;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         us_hotrst_rx = 1'b0, us_dl_down = 1'b0, ctl_no_ld_rst = 1'b0;
    logic         sw_part_rst_wr = 1'b0, sw_sbr_wr = 1'b0;
    logic [N-1:0] dsp_link_up = '0, dsp_link_dis = '0;
    logic [N-1:0] dsp_send_hot, dsp_go_detect;
    logic         part_logic_rst, nonsticky_clr, train_release;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    part_rst_seq #(.NUM_DSP(N)) u_part_rst_seq (
        .clk(clk), .rst_n(rst_n),
        .us_hotrst_rx(us_hotrst_rx), .us_dl_down(us_dl_down),
        .ctl_no_ld_rst(ctl_no_ld_rst),
        .sw_part_rst_wr(sw_part_rst_wr), .sw_sbr_wr(sw_sbr_wr),
        .dsp_link_up(dsp_link_up), .dsp_link_dis(dsp_link_dis),
        .dsp_send_hot(dsp_send_hot), .dsp_go_detect(dsp_go_detect),
        .part_logic_rst(part_logic_rst), .nonsticky_clr(nonsticky_clr),
        .train_release(train_release)
    );

    // trig = {sbr, sw_hot, dl_down, hot_rx}
    typedef struct packed {
        logic [3:0]   trig;
        logic         mask;
        logic [N-1:0] up;
        logic [N-1:0] dis;
        logic [N-1:0] e_send;
        logic [N-1:0] e_det;
        logic         e_prst;
        logic         e_fire;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{4'b0001, 1'b0, 4'b1111, 4'b0000, 4'b1111, 4'b0000, 1'b1, 1'b1}, // R1 R4 rx
        '{4'b0010, 1'b0, 4'b0101, 4'b1000, 4'b0101, 4'b1000, 1'b1, 1'b1}, // R1 R5 dl
        '{4'b0010, 1'b1, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0}, // R2 masked
        '{4'b0001, 1'b1, 4'b0011, 4'b0100, 4'b0011, 4'b0100, 1'b1, 1'b1}, // R3
        '{4'b0100, 1'b0, 4'b1001, 4'b0110, 4'b1001, 4'b0110, 1'b1, 1'b1}, // R1 sw
        '{4'b1000, 1'b0, 4'b0110, 4'b1001, 4'b0110, 4'b0000, 1'b0, 1'b1}, // R9 sbr
        '{4'b1001, 1'b0, 4'b1100, 4'b0001, 4'b1100, 4'b0001, 1'b1, 1'b1}  // R9 hot wins
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_trig();
        us_hotrst_rx = 1'b0; us_dl_down = 1'b0;
        sw_part_rst_wr = 1'b0; sw_sbr_wr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 send", 32'(dsp_send_hot), 0);
        chk("R11 det", 32'(dsp_go_detect), 0);
        chk("R11 prst", 32'(part_logic_rst), 0);
        chk("R11 nsr/rel", 32'({nonsticky_clr, train_release}), 0);
        rst_n = 1'b1;
        step();

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            ctl_no_ld_rst = VECS[v].mask;
            dsp_link_up   = VECS[v].up;
            dsp_link_dis  = VECS[v].dis;
            {sw_sbr_wr, sw_part_rst_wr, us_dl_down, us_hotrst_rx} = VECS[v].trig;
            step(); // launch cycle
            chk("R4 send", 32'(dsp_send_hot), 32'(VECS[v].e_send));
            chk("R5 det", 32'(dsp_go_detect), 32'(VECS[v].e_det));
            chk("R1 prst", 32'(part_logic_rst), 32'(VECS[v].e_prst));
            chk("R6 nsr", 32'(nonsticky_clr), 32'(VECS[v].e_prst));
            clear_trig();
            step(); // hold (one cycle)
            chk("R7 prst hold", 32'(part_logic_rst), 32'(VECS[v].e_prst));
            chk("R6 nsr off", 32'({nonsticky_clr, dsp_send_hot}), 0);
            step(); // release
            chk("R8 rel", 32'(train_release), 32'(VECS[v].e_fire));
            chk("R8 prst low", 32'(part_logic_rst), 0);
            step(); // idle
            chk("R8 idle", 32'({train_release, part_logic_rst, dsp_send_hot, dsp_go_detect}), 0);
            ctl_no_ld_rst = 1'b0;
        end

        // R7: hold persists while rx stays high
        dsp_link_up = 4'b1111; dsp_link_dis = 4'b0000;
        us_hotrst_rx = 1'b1;
        step();
        chk("R7 launch", 32'(part_logic_rst), 1);
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R7 held", 32'({part_logic_rst, train_release, nonsticky_clr}), 32'b100);
        end
        // R10: sw sbr pulse during hold is remembered
        sw_sbr_wr = 1'b1;
        step();
        sw_sbr_wr = 1'b0;
        chk("R7 held sbr", 32'(part_logic_rst), 1);
        dsp_link_up = 4'b0011; dsp_link_dis = 4'b1100;
        us_hotrst_rx = 1'b0;
        step();
        chk("R8 rel after hold", 32'({train_release, part_logic_rst}), 32'b10);
        step(); // pending sbr launches from release
        chk("R10 pend send", 32'(dsp_send_hot), 32'(4'b0011));
        chk("R10 pend kind", 32'({part_logic_rst, nonsticky_clr, dsp_go_detect}), 0);
        step(); step();
        chk("R10 rel", 32'(train_release), 1);
        // R10: level source during release re-enters launch
        us_dl_down = 1'b1;
        dsp_link_up = 4'b0001; dsp_link_dis = 4'b0000;
        step();
        chk("R10 relaunch", 32'({part_logic_rst, nonsticky_clr, dsp_send_hot}), 32'b110001);
        us_dl_down = 1'b0;
        step(); step();
        chk("R8 rel 2", 32'(train_release), 1);
        step();
        chk("R8 idle 2", 32'({train_release, part_logic_rst}), 0);

        // R2: masked link-down held for several cycles, nothing happens
        ctl_no_ld_rst = 1'b1; us_dl_down = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R2 masked", 32'({part_logic_rst, train_release, dsp_send_hot}), 0);
        end
        clear_trig(); ctl_no_ld_rst = 1'b0;

        // R11: reset during hold clears everything
        us_hotrst_rx = 1'b1;
        step(); step();
        rst_n = 1'b0;
        step();
        chk("R11 mid reset", 32'({part_logic_rst, nonsticky_clr, train_release, dsp_send_hot}), 0);
        clear_trig(); rst_n = 1'b1;
        step();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule